// File: doc/BRIEF.md
# Manchester II Word Encoder for a Dual-Sense Serial Bus

This block turns one 16-bit word, fetched bit by bit from an outside data source, into a self-clocking Manchester II waveform. The waveform goes out on two active-low drive pins, one for each sense of a differential line driver. Each word starts with a three-bit-time sync character. The sync is not valid Manchester, and its polarity shows whether a command word or a data word follows. The sixteen data bits come next, and an odd-parity bit ends the word.

The encoder runs on a clock at twice the bit rate, so one clock cycle is one half-bit. A small divider inside the block derives that clock from a master clock at twelve times the bit rate, and the integrator normally loops the divider output back into the encoder clock pin. The data source is paced by two outputs: a fetch window and a bit-rate shift clock. An enable input can silence the drive pins at any time without disturbing the word timing. A start request that arrives during the final half-bit of a word makes the next word follow with no idle gap.

Top module: `mil_word_encoder`

## Requirements
- R1: `div6_out` changes level on every third rising edge of `clk_12x`, so its period is six `clk_12x` cycles with an even duty. While `mreset` is high it stays low.
- R2: While no word is in progress, `bip_one_n` and `bip_zero_n` are both high and `send_data` is low. The two drive pins are never low together.
- R3: `enc_start` is taken at a rising edge of `enc_clk` only if `shift_clk` is high before that edge and no word is in progress or the current half-bit is the last of a word. The word's first half-bit begins at that edge. A request held only while `shift_clk` is low is ignored.
- R4: A "positive" half-bit drives `bip_one_n` low and `bip_zero_n` high. A "negative" half-bit does the reverse. With `sync_sel` high when the word is taken, half-bits 0 to 2 are positive and 3 to 5 are negative. With `sync_sel` low the order is reversed.
- R5: Half-bits 6 to 37 carry the 16 data bits in the order received. A 1 is a positive half-bit followed by a negative one, and a 0 is the reverse. Bit k is the `ser_in` level sampled at the `enc_clk` edge that ends half-bit 5+2k.
- R6: Half-bits 38 and 39 carry a parity bit in the same Manchester code. It is chosen so that the 16 data bits plus parity hold an odd number of ones.
- R7: `shift_clk` toggles on every `enc_clk` edge. It is low in the first half and high in the second half of every bit time of a word. `send_data` is high exactly during half-bits 4 to 35, which gives the source 16 rising `shift_clk` edges while it is high.
- R8: While `drive_en` is low, both drive pins are high in that same cycle. The word's progress and its later half-bits are unaffected.
- R9: `mreset` high aborts any word at once, clears the divider and the half-bit phase, and returns all outputs to the idle state.
- R10: With `enc_start` held high across the last half-bit of a word, the next word's sync begins in the very next half-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_12x | input | 1 | Master clock at 12x the bit rate, feeds the divider |
| mreset | input | 1 | Asynchronous active-high reset for divider and encoder |
| div6_out | output | 1 | `clk_12x` divided by 6 (2x bit rate) |
| enc_clk | input | 1 | Encoder clock at 2x bit rate, normally tied to `div6_out` |
| enc_start | input | 1 | Request to begin a word |
| sync_sel | input | 1 | High selects the command sync, low the data sync |
| ser_in | input | 1 | Serial data from the external source |
| drive_en | input | 1 | Low forces both drive pins inactive |
| shift_clk | output | 1 | Bit-rate clock for the data source, rises mid-bit |
| send_data | output | 1 | High while the source should shift out data |
| bip_one_n | output | 1 | Active-low positive-sense drive |
| bip_zero_n | output | 1 | Active-low negative-sense drive |

## Verification
Two functions can fall in the same cycle: the completion of a word, during its second parity half-bit, and the acceptance of a new start request. The bench provokes this by holding `enc_start` high through the whole of one word while changing the word and the sync choice for the next. A behavioural queue model of the expected half-bit levels must then see the new sync appear in the very next cycle, with no idle half-bit in between. The drive gate is also switched off and on in the middle of a word, and the model checks that the half-bits after it stay in step.

// File: rtl/mil_word_encoder.sv
module mil_word_encoder #(
  parameter int DATA_BITS   = 16,
  parameter int SYNC_HALVES = 6,
  parameter int DIV         = 6
) (
  input  logic clk_12x,
  input  logic mreset,
  output logic div6_out,
  input  logic enc_clk,
  input  logic enc_start,
  input  logic sync_sel,
  input  logic ser_in,
  input  logic drive_en,
  output logic shift_clk,
  output logic send_data,
  output logic bip_one_n,
  output logic bip_zero_n
);

  localparam int DIV_HALF    = DIV / 2;
  localparam int DCW         = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int PAR_START   = SYNC_HALVES + 2 * DATA_BITS;
  localparam int WORD_HALVES = PAR_START + 2;
  localparam int HB_W        = $clog2(WORD_HALVES + 1);

  localparam logic [DCW-1:0]  DCNT_TOP   = DCW'(DIV_HALF - 1);
  localparam logic [HB_W-1:0] HB_LAST    = HB_W'(WORD_HALVES - 1);
  localparam logic [HB_W-1:0] HB_SYNC    = HB_W'(SYNC_HALVES);
  localparam logic [HB_W-1:0] HB_SYNC_MID = HB_W'(SYNC_HALVES / 2);
  localparam logic [HB_W-1:0] HB_SEND_LO = HB_W'(SYNC_HALVES - 2);
  localparam logic [HB_W-1:0] HB_SEND_HI = HB_W'(PAR_START - 3);
  localparam logic [HB_W-1:0] HB_TAKE_LO = HB_W'(SYNC_HALVES - 1);
  localparam logic [HB_W-1:0] HB_PAR_SET = HB_W'(PAR_START - 1);

  // divide-by-6 helper
  logic [DCW-1:0] dcnt;

  always_ff @(posedge clk_12x or posedge mreset)
    if (mreset) begin
      dcnt     <= '0;
      div6_out <= 1'b0;
    end else if (dcnt == DCNT_TOP) begin
      dcnt     <= '0;
      div6_out <= ~div6_out;
    end else begin
      dcnt <= dcnt + 1'b1;
    end

  AST_DIV6_HOLD: assert property (@(posedge clk_12x) disable iff (mreset)
    (dcnt != DCNT_TOP) |=> $stable(div6_out)); // R1

  // encoder
  logic            half, busy, cmd, cur, acc;
  logic [HB_W-1:0] hb;
  logic            last, take, in_sync, level;

  assign last    = busy && (hb == HB_LAST);
  assign take    = enc_start && half && (!busy || last);
  assign in_sync = hb < HB_SYNC;
  assign level   = in_sync ? ((hb < HB_SYNC_MID) ? cmd : ~cmd) : (cur ^ half);

  always_ff @(posedge enc_clk or posedge mreset)
    if (mreset) begin
      half <= 1'b0;
      busy <= 1'b0;
      cmd  <= 1'b0;
      cur  <= 1'b0;
      acc  <= 1'b0;
      hb   <= '0;
    end else begin
      half <= ~half;
      if (take) begin
        busy <= 1'b1;
        hb   <= '0;
        cmd  <= sync_sel;
        acc  <= 1'b0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        hb <= hb + 1'b1;
        if (half && hb >= HB_TAKE_LO && hb <= HB_SEND_HI) begin
          cur <= ser_in;
          acc <= acc ^ ser_in;
        end
        if (hb == HB_PAR_SET) cur <= ~acc;
      end
    end

  assign shift_clk  = half;
  assign send_data  = busy && hb >= HB_SEND_LO && hb <= HB_SEND_HI;
  assign bip_one_n  = ~(busy & drive_en & level);
  assign bip_zero_n = ~(busy & drive_en & ~level);

  AST_IDLE_QUIET: assert property (@(posedge enc_clk) disable iff (mreset)
    !busy |-> (bip_one_n && bip_zero_n && !send_data)); // R2
  AST_LINE_EXCL: assert property (@(posedge enc_clk) disable iff (mreset)
    (bip_one_n || bip_zero_n)); // R2
  AST_START_ALIGN: assert property (@(posedge enc_clk) disable iff (mreset)
    $rose(busy) |-> !half); // R3
  AST_MID_FLIP: assert property (@(posedge enc_clk) disable iff (mreset)
    (busy && half && hb >= HB_SYNC) |-> (level != $past(level))); // R5
  AST_PHASE_TOGGLE: assert property (@(posedge enc_clk) disable iff (mreset)
    half |=> !half); // R7
  AST_SEND_IN_WORD: assert property (@(posedge enc_clk) disable iff (mreset)
    send_data |-> busy); // R7

endmodule

// File: tb/sim_mil_word_encoder.sv
module sim_mil_word_encoder;
  logic clk12 = 1'b0;
  logic mreset = 1'b0;
  logic d6;
  logic enc_start = 1'b0, sync_sel = 1'b0, ser_in = 1'b0, drive_en = 1'b1;
  logic shift_clk, send_data, bip_one_n, bip_zero_n;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk12 = ~clk12;

  mil_word_encoder u0 (
    .clk_12x(clk12), .mreset(mreset), .div6_out(d6), .enc_clk(d6),
    .enc_start(enc_start), .sync_sel(sync_sel), .ser_in(ser_in),
    .drive_en(drive_en), .shift_clk(shift_clk), .send_data(send_data),
    .bip_one_n(bip_one_n), .bip_zero_n(bip_zero_n));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference model
  logic        q[$];
  int          m_half = 0, m_hb = 0, accepts = 0;
  bit          m_busy = 0, m_lvl = 0, m_b2b = 0, cur_b2b = 0;
  logic [15:0] tb_word = 16'h0, src_word = 16'h0;
  int          src_idx = 0;
  bit          prev_sc = 0;

  always @(posedge d6 or posedge mreset) begin
    if (mreset) begin
      q.delete();
      m_half = 0; m_busy = 0; m_hb = 0; m_b2b = 0; cur_b2b = 0;
      src_idx = 0; prev_sc = 0;
    end else begin
      if (enc_start && m_half == 1 && q.size() == 0) begin
        m_b2b = m_busy;
        src_word = tb_word;
        src_idx = 0;
        accepts++;
        for (int i = 0; i < 3; i++) q.push_back(sync_sel);
        for (int i = 0; i < 3; i++) q.push_back(!sync_sel);
        for (int k = 15; k >= 0; k--) begin
          q.push_back(tb_word[k]);
          q.push_back(!tb_word[k]);
        end
        q.push_back(~^tb_word);
        q.push_back(^tb_word);
      end
      m_half = 1 - m_half;
      if (q.size() > 0) begin
        m_lvl = q.pop_front();
        m_busy = 1;
        m_hb = 39 - q.size();
        if (m_hb == 0) cur_b2b = m_b2b;
      end else begin
        m_busy = 0;
      end
    end
  end

  // compare every cycle, then the modelled data source shifts
  always @(negedge d6) begin
    if (!mreset) begin
      bit e_one, e_zero, e_send;
      string tag;
      e_one  = !(m_busy && drive_en && m_lvl);
      e_zero = !(m_busy && drive_en && !m_lvl);
      e_send = m_busy && m_hb >= 4 && m_hb <= 35;
      if (!m_busy) tag = "R2";
      else if (!drive_en) tag = "R8";
      else if (m_hb < 6 && cur_b2b) tag = "R10";
      else if (m_hb == 0) tag = "R3";
      else if (m_hb < 6) tag = "R4";
      else if (m_hb < 38) tag = "R5";
      else tag = "R6";
      chk(bip_one_n == e_one, tag, "bip_one_n", bip_one_n, e_one);
      chk(bip_zero_n == e_zero, tag, "bip_zero_n", bip_zero_n, e_zero);
      chk(send_data == e_send, "R7", "send_data", send_data, e_send);
      chk(shift_clk == m_half[0], "R7", "shift_clk", shift_clk, m_half);
      if (shift_clk && !prev_sc && send_data && src_idx < 16) begin
        ser_in = src_word[15 - src_idx];
        src_idx++;
      end
      prev_sc = shift_clk;
    end
  end

  int c12 = 0;
  always @(posedge clk12) c12++;

  task automatic step();
    @(posedge d6);
    #2;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      step();
      if (!m_busy && q.size() == 0) break;
    end
  endtask

  task automatic send_word(input logic [15:0] w, input bit s);
    int old;
    old = accepts;
    tb_word = w; sync_sel = s; enc_start = 1;
    for (int i = 0; i < 10 && accepts == old; i++) step();
    enc_start = 0;
    wait_idle();
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int t0, t1, t2;
    #1 mreset = 1;
    #5;
    chk(d6 == 0, "R1", "div6_out in reset", d6, 0);
    chk(bip_one_n == 1 && bip_zero_n == 1, "R2", "drive pins in reset", {bip_one_n, bip_zero_n}, 3);
    chk(send_data == 0, "R2", "send_data in reset", send_data, 0);
    chk(shift_clk == 0, "R9", "shift_clk in reset", shift_clk, 0);
    @(negedge clk12); mreset = 0;

    // R1 divider period and duty
    @(posedge d6); t0 = c12;
    @(negedge d6); t1 = c12;
    @(posedge d6); t2 = c12;
    chk(t1 - t0 == 3, "R1", "div6 high span", t1 - t0, 3);
    chk(t2 - t0 == 6, "R1", "div6 period", t2 - t0, 6);
    #2;

    send_word(16'hA5C3, 1);
    send_word(16'h0000, 0);
    send_word(16'hFFFF, 1);
    send_word(16'h0001, 0);
    send_word(16'h8000, 1);

    // R10 back-to-back with sync change
    begin
      int old;
      old = accepts;
      tb_word = 16'h1234; sync_sel = 1; enc_start = 1;
      for (int i = 0; i < 10 && accepts == old; i++) step();
      tb_word = 16'hFEDC; sync_sel = 0;
      for (int i = 0; i < 60 && accepts == old + 1; i++) step();
      enc_start = 0;
      chk(accepts == old + 2, "R10", "back-to-back accepts", accepts - old, 2);
      wait_idle();
    end

    // R8 gate mid-word
    tb_word = 16'h5AA5; sync_sel = 1; enc_start = 1;
    step(); step();
    enc_start = 0;
    repeat (8) step();
    drive_en = 0;
    repeat (9) step();
    drive_en = 1;
    wait_idle();

    // R3 request only during first half is ignored
    while (shift_clk != 0) step();
    begin
      int old, active;
      old = accepts; active = 0;
      tb_word = 16'h7777; enc_start = 1;
      step();
      enc_start = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge d6);
        if (!bip_one_n || !bip_zero_n) active++;
      end
      chk(active == 0 && accepts == old, "R3", "misaligned request started a word", active, 0);
      #2;
    end

    // R9 reset mid-word
    tb_word = 16'hC3C3; sync_sel = 0; enc_start = 1;
    step(); step();
    enc_start = 0;
    repeat (12) step();
    mreset = 1;
    #3;
    chk(bip_one_n && bip_zero_n, "R9", "drive pins after abort", {bip_one_n, bip_zero_n}, 3);
    chk(send_data == 0, "R9", "send_data after abort", send_data, 0);
    chk(d6 == 0 && shift_clk == 0, "R9", "divider and phase after abort", {d6, shift_clk}, 0);
    repeat (5) @(posedge clk12);
    @(negedge clk12); mreset = 0;
    #2;
    send_word(16'h0F0F, 1);

    repeat (4) step();
    finish_run();
  end
endmodule